// File: doc/BRIEF.md
# Staged Over-Temperature Alarm

This block models an over-temperature alarm that software configures through a small port of byte-wide registers. A digital temperature arrives in millidegrees Celsius. A two-bit row select picks one row of a four-row table, and each row holds three trip levels. The current stage is the number of those levels that the temperature has reached. The stage appears in a status register. It also drives two shutdown requests, and an interrupt pulse marks each change of stage.

Monitoring is off until software sets the enable bit. While enabled, a three-state controller starts in `ST_OFF`, the idle state while enable is clear. It moves to `ST_COUNT` when enable is set, and there it counts toward the next monitoring tick. When the count reaches the current rate's limit it moves to `ST_EVAL`, a single cycle in which the compared stage is captured. From `ST_EVAL` it returns to `ST_COUNT`. Clearing enable sends it from any state back to `ST_OFF`. A control bit chooses between a fast tick divider and a slow one.

Two build options are available: first-generation or second-generation status format, and a fixed digital-revision value. Together they also choose which trip table is used.

Top module: `thermal_stage_alarm`

## Requirements
- R1: Offset 0x01 reads the REV_MAJOR parameter. Offset 0x04 reads 0x09. Offset 0x05 reads 0x08 when GEN2=0 and 0x09 when GEN2=1. Any unmapped offset reads 0x00. Writes to these read-only offsets change nothing.
- R2: The shutdown-control register is at offset 0x40. Bits [1:0] hold the table row, bit 3 selects the fast rate and bit 6 sets the stage-2 override; its other bits read 0. The alarm-control register is at offset 0x46; bit 7 is the enable and its other bits read 0. After reset both registers, and status, read 0x00.
- R3: The three trip levels of row r are at {90, 110, 140} C plus 5 C times r when GEN2=1 and REV_MAJOR is 1 or more. Otherwise they are at {105, 125, 145} C plus 5 C times r. Levels are compared in millidegrees.
- R4: The stage is the count of trip levels that the temperature is greater than or equal to, from 0 to 3.
- R5: Status sits at offset 0x08. With GEN2=0, bits [1:0] hold the stage. With GEN2=1, bits [6:4] hold the state code 0, 1, 3 or 5 for stages 0, 1, 2 or 3. All other status bits read 0.
- R6: While the enable bit is clear, the stage stays 0 and the interrupt and both shutdowns stay low, whatever the temperature.
- R7: While enabled, the stage is captured once per tick. A tick comes every FAST_DIV cycles when bit 3 is set and every SLOW_DIV cycles when it is clear. Between ticks the reported stage does not change.
- R8: `alarm_irq` is a one-cycle pulse in the cycle the reported stage takes a new value at a tick. A tick that leaves the stage unchanged gives no pulse.
- R9: `shdn_stage3` is high exactly when the stage is 3, and the override does not affect it.
- R10: `shdn_stage2` is high when the stage is 2 or more and the override bit is clear. It is low whenever the override bit is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register offset for reads and writes |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| temp_mdc | input | TEMP_W | Temperature in millidegrees Celsius |
| alarm_irq | output | 1 | Stage-change interrupt pulse |
| shdn_stage2 | output | 1 | Stage-2 shutdown request |
| shdn_stage3 | output | 1 | Stage-3 shutdown request |

## Verification
The bench places temperatures exactly on each trip level and one millidegree below it, in several rows and in both table variants. A design that compares with strict greater-than, or that ignores the row offset, would report a stage one too low or one too high. It measures the distance from one stage-change pulse to the next capture at both rates. An off-by-one divider, or a stage that tracks the temperature between ticks, would show the new stage a cycle early or late. It also checks the override against stage 2 and stage 3, holds the temperature high while the block is disabled, and changes the temperature inside one stage. A design that lets the override mask stage 3, that monitors before enable, or that pulses on every tick would fail these checks.

// File: rtl/tsa_pkg.sv
package tsa_pkg;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_COUNT = 2'd1,
        ST_EVAL  = 2'd2
    } tsa_state_e;

    localparam int unsigned NUM_LVL = 3;
    localparam int unsigned STG_W   = 2;
    localparam int unsigned ROW_W   = 2;

    localparam logic [7:0] OFS_REV     = 8'h01;
    localparam logic [7:0] OFS_TYPE    = 8'h04;
    localparam logic [7:0] OFS_SUBTYPE = 8'h05;
    localparam logic [7:0] OFS_STATUS  = 8'h08;
    localparam logic [7:0] OFS_SDCTRL  = 8'h40;
    localparam logic [7:0] OFS_ALMCTRL = 8'h46;

    localparam logic [7:0] TYPE_VAL       = 8'h09;
    localparam logic [7:0] SUBTYPE_FIRST  = 8'h08;
    localparam logic [7:0] SUBTYPE_SECOND = 8'h09;

    localparam int unsigned ROW_STEP_MDC = 5000;

    // Row-0 trip level in millidegrees for level index lvl.
    function automatic int unsigned trip_base_mdc(input bit second, input int unsigned lvl);
        int unsigned v;
        if (second) begin
            v = (lvl == 0) ? 90000 : (lvl == 1) ? 110000 : 140000;
        end else begin
            v = (lvl == 0) ? 105000 : (lvl == 1) ? 125000 : 145000;
        end
        return v;
    endfunction

    // Second-format status code for a stage.
    function automatic logic [2:0] stage_to_code(input logic [STG_W-1:0] stg);
        logic [2:0] c;
        case (stg)
            2'd0:    c = 3'd0;
            2'd1:    c = 3'd1;
            2'd2:    c = 3'd3;
            default: c = 3'd5;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/tsa_stage_eval.sv
module tsa_stage_eval
    import tsa_pkg::*;
#(
    parameter int unsigned TEMP_W       = 18,
    parameter bit          SECOND_TABLE = 1'b1
) (
    input  logic [TEMP_W-1:0] temp_mdc,
    input  logic [ROW_W-1:0]  row,
    output logic [STG_W-1:0]  stage
);

    logic [NUM_LVL-1:0] hit;

    for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
        localparam logic [TEMP_W-1:0] BASE = TEMP_W'(trip_base_mdc(SECOND_TABLE, l));
        logic [TEMP_W-1:0] level_mdc;
        assign level_mdc = BASE + (TEMP_W'(row) * TEMP_W'(ROW_STEP_MDC));
        assign hit[l]    = (temp_mdc >= level_mdc);
    end

    always_comb begin
        stage = '0;
        for (int i = 0; i < NUM_LVL; i++) begin
            if (hit[i]) begin
                stage = stage + STG_W'(1);
            end
        end
    end

endmodule

// File: rtl/tsa_regfile.sv
module tsa_regfile
    import tsa_pkg::*;
#(
    parameter bit         GEN2      = 1'b1,
    parameter logic [7:0] REV_MAJOR = 8'h01
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wen,
    input  logic [7:0]       addr,
    input  logic [7:0]       wdata,
    input  logic [STG_W-1:0] stage,
    output logic [7:0]       rdata,
    output logic             en_q,
    output logic [ROW_W-1:0] row_q,
    output logic             fast_q,
    output logic             ovr_q
);

    logic [7:0] status_val;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            row_q  <= '0;
            fast_q <= 1'b0;
            ovr_q  <= 1'b0;
        end else if (wen) begin
            if (addr == OFS_SDCTRL) begin
                row_q  <= wdata[1:0];
                fast_q <= wdata[3];
                ovr_q  <= wdata[6];
            end
            if (addr == OFS_ALMCTRL) begin
                en_q <= wdata[7];
            end
        end
    end

    if (GEN2) begin : g_fmt_second
        assign status_val = {1'b0, stage_to_code(stage), 4'b0000};
    end else begin : g_fmt_first
        assign status_val = {6'b000000, stage};
    end

    always_comb begin
        case (addr)
            OFS_REV:     rdata = REV_MAJOR;
            OFS_TYPE:    rdata = TYPE_VAL;
            OFS_SUBTYPE: rdata = GEN2 ? SUBTYPE_SECOND : SUBTYPE_FIRST;
            OFS_STATUS:  rdata = status_val;
            OFS_SDCTRL:  rdata = {1'b0, ovr_q, 2'b00, fast_q, 1'b0, row_q};
            OFS_ALMCTRL: rdata = {en_q, 7'b0000000};
            default:     rdata = 8'h00;
        endcase
    end

endmodule

// File: rtl/tsa_tick_fsm.sv
module tsa_tick_fsm
    import tsa_pkg::*;
#(
    parameter int unsigned FAST_DIV = 8,
    parameter int unsigned SLOW_DIV = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             fast,
    input  logic [STG_W-1:0] stage_in,
    output logic [STG_W-1:0] stage_q,
    output logic             irq_q,
    output logic             eval_now
);

    localparam int unsigned MAX_DIV = (FAST_DIV > SLOW_DIV) ? FAST_DIV : SLOW_DIV;
    localparam int unsigned CNT_W   = (MAX_DIV > 2) ? $clog2(MAX_DIV) : 1;

    tsa_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] lim_m2;
    logic             at_lim;

    assign lim_m2   = fast ? CNT_W'(FAST_DIV - 2) : CNT_W'(SLOW_DIV - 2);
    assign at_lim   = (cnt_q >= lim_m2);
    assign eval_now = (state_q == ST_EVAL);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (en) state_d = ST_COUNT;
            end
            ST_COUNT: begin
                if (!en)        state_d = ST_OFF;
                else if (at_lim) state_d = ST_EVAL;
            end
            ST_EVAL: begin
                state_d = en ? ST_COUNT : ST_OFF;
            end
            default: state_d = ST_OFF;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // Tick divider
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (state_q == ST_COUNT && state_d == ST_COUNT) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end else begin
            cnt_q <= '0;
        end
    end

    // Outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
            irq_q   <= 1'b0;
        end else if (!en) begin
            stage_q <= '0;
            irq_q   <= 1'b0;
        end else if (state_q == ST_EVAL) begin
            stage_q <= stage_in;
            irq_q   <= (stage_in != stage_q);
        end else begin
            irq_q   <= 1'b0;
        end
    end

endmodule

// File: rtl/thermal_stage_alarm.sv
module thermal_stage_alarm
    import tsa_pkg::*;
#(
    parameter bit          GEN2      = 1'b1,
    parameter logic [7:0]  REV_MAJOR = 8'h01,
    parameter int unsigned TEMP_W    = 18,
    parameter int unsigned FAST_DIV  = 8,
    parameter int unsigned SLOW_DIV  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wen,
    input  logic [7:0]        reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic [TEMP_W-1:0] temp_mdc,
    output logic              alarm_irq,
    output logic              shdn_stage2,
    output logic              shdn_stage3
);

    localparam bit SECOND_TABLE = GEN2 && (REV_MAJOR >= 8'h01);

    logic             en_q;
    logic [ROW_W-1:0] row_q;
    logic             fast_q;
    logic             ovr_q;
    logic [STG_W-1:0] stage_cmp;
    logic [STG_W-1:0] stage_q;
    logic             eval_now;

    tsa_regfile #(
        .GEN2      (GEN2),
        .REV_MAJOR (REV_MAJOR)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wen    (reg_wen),
        .addr   (reg_addr),
        .wdata  (reg_wdata),
        .stage  (stage_q),
        .rdata  (reg_rdata),
        .en_q   (en_q),
        .row_q  (row_q),
        .fast_q (fast_q),
        .ovr_q  (ovr_q)
    );

    tsa_stage_eval #(
        .TEMP_W       (TEMP_W),
        .SECOND_TABLE (SECOND_TABLE)
    ) u_eval (
        .temp_mdc (temp_mdc),
        .row      (row_q),
        .stage    (stage_cmp)
    );

    tsa_tick_fsm #(
        .FAST_DIV (FAST_DIV),
        .SLOW_DIV (SLOW_DIV)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en_q),
        .fast     (fast_q),
        .stage_in (stage_cmp),
        .stage_q  (stage_q),
        .irq_q    (alarm_irq),
        .eval_now (eval_now)
    );

    assign shdn_stage2 = (stage_q >= STG_W'(2)) && !ovr_q;
    assign shdn_stage3 = (stage_q == STG_W'(3));

endmodule

// File: rtl/thermal_stage_alarm_chk.sv
module thermal_stage_alarm_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       en,
    input logic       ovr,
    input logic [1:0] stage,
    input logic       eval_now,
    input logic       irq,
    input logic       shdn_s2,
    input logic       shdn_s3
);

    p_irq_one_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    p_irq_on_change_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (stage != $past(stage)));

    p_stage_at_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(stage) |-> ($past(eval_now) || !$past(en)));

    p_idle_when_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> ((stage == 2'd0) && !irq && !shdn_s3));

    p_override_masks_s2_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ovr |-> !shdn_s2);

    p_s3_implies_s2_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (shdn_s3 && !ovr) |-> shdn_s2);

endmodule

bind thermal_stage_alarm thermal_stage_alarm_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en_q),
    .ovr      (ovr_q),
    .stage    (stage_q),
    .eval_now (eval_now),
    .irq      (alarm_irq),
    .shdn_s2  (shdn_stage2),
    .shdn_s3  (shdn_stage3)
);

// File: tb/thermal_stage_alarm_bench.sv
`timescale 1ns/1ps
module thermal_stage_alarm_bench;

    localparam int FAST = 8;
    localparam int SLOW = 32;
    localparam int TW   = 18;

    // {row[1:0], temp_mdc[17:0], stage second table[1:0], stage first table[1:0]}
    localparam logic [23:0] VEC [0:15] = '{
        {2'd0, 18'd37000,  2'd0, 2'd0},
        {2'd0, 18'd89999,  2'd0, 2'd0},
        {2'd0, 18'd90000,  2'd1, 2'd0},
        {2'd0, 18'd105000, 2'd1, 2'd1},
        {2'd0, 18'd110000, 2'd2, 2'd1},
        {2'd0, 18'd125000, 2'd2, 2'd2},
        {2'd0, 18'd140000, 2'd3, 2'd2},
        {2'd0, 18'd145000, 2'd3, 2'd3},
        {2'd3, 18'd104999, 2'd0, 2'd0},
        {2'd3, 18'd105000, 2'd1, 2'd0},
        {2'd3, 18'd125000, 2'd2, 2'd1},
        {2'd3, 18'd155000, 2'd3, 2'd2},
        {2'd3, 18'd160000, 2'd3, 2'd3},
        {2'd1, 18'd114999, 2'd1, 2'd1},
        {2'd2, 18'd150000, 2'd3, 2'd2},
        {2'd1, 18'd0,      2'd0, 2'd0}
    };

    logic          clk = 1'b0;
    logic          rst_n;
    logic          reg_wen;
    logic [7:0]    reg_addr;
    logic [7:0]    reg_wdata;
    logic [TW-1:0] temp_mdc;
    logic [7:0]    rdata_m, rdata_g;
    logic          irq_m, irq_g, s2_m, s2_g, s3_m, s3_g;

    int n_cmp = 0;
    int n_bad = 0;
    int irq_cnt = 0;
    int irq_wide = 0;
    logic irq_prev = 1'b0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    thermal_stage_alarm #(
        .GEN2(1'b1), .REV_MAJOR(8'h01), .TEMP_W(TW), .FAST_DIV(FAST), .SLOW_DIV(SLOW)
    ) u_thermal_stage_alarm (
        .clk(clk), .rst_n(rst_n), .reg_wen(reg_wen), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(rdata_m), .temp_mdc(temp_mdc),
        .alarm_irq(irq_m), .shdn_stage2(s2_m), .shdn_stage3(s3_m)
    );

    thermal_stage_alarm #(
        .GEN2(1'b0), .REV_MAJOR(8'h00), .TEMP_W(TW), .FAST_DIV(FAST), .SLOW_DIV(SLOW)
    ) u_gen1 (
        .clk(clk), .rst_n(rst_n), .reg_wen(reg_wen), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(rdata_g), .temp_mdc(temp_mdc),
        .alarm_irq(irq_g), .shdn_stage2(s2_g), .shdn_stage3(s3_g)
    );

    always @(negedge clk) begin
        if (irq_m === 1'b1) irq_cnt++;
        if (irq_m === 1'b1 && irq_prev === 1'b1) irq_wide++;
        irq_prev = irq_m;
    end

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wen = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wen = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] m, output logic [7:0] g);
        @(negedge clk);
        reg_addr = a;
        #1;
        m = rdata_m; g = rdata_g;
    endtask

    task automatic wait_irq(input int lim, input string req);
        bit seen = 1'b0;
        for (int k = 0; k < lim && !seen; k++) begin
            @(negedge clk);
            #1;
            if (irq_m === 1'b1) seen = 1'b1;
        end
        if (!seen) check(req, "stage-change pulse seen", 0, 1);
    endtask

    function automatic logic [7:0] code_of(input logic [1:0] s);
        case (s)
            2'd0: return 8'h00;
            2'd1: return 8'h10;
            2'd2: return 8'h30;
            default: return 8'h50;
        endcase
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(4 * 150000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] m, g;
        int base;
        rst_n = 1'b0; reg_wen = 1'b0; reg_addr = 8'h00; reg_wdata = 8'h00;
        temp_mdc = TW'(37000);
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R2 reset values
        rd(8'h40, m, g); check("R2", "sdctrl reset", m, 8'h00); check("R2", "sdctrl reset first", g, 8'h00);
        rd(8'h46, m, g); check("R2", "almctrl reset", m, 8'h00);
        rd(8'h08, m, g); check("R2", "status reset", m, 8'h00);
        check("R2", "outputs reset", {irq_m, s2_m, s3_m}, 3'b000);

        // R1 identification
        rd(8'h01, m, g); check("R1", "rev second", m, 8'h01); check("R1", "rev first", g, 8'h00);
        rd(8'h04, m, g); check("R1", "type second", m, 8'h09); check("R1", "type first", g, 8'h09);
        rd(8'h05, m, g); check("R1", "subtype second", m, 8'h09); check("R1", "subtype first", g, 8'h08);
        rd(8'h02, m, g); check("R1", "unmapped 0x02", m, 8'h00);
        rd(8'h41, m, g); check("R1", "unmapped 0x41", m, 8'h00);
        wr(8'h04, 8'h55);
        rd(8'h04, m, g); check("R1", "type after write", m, 8'h09);

        // R2 field masks
        wr(8'h40, 8'hFF); rd(8'h40, m, g); check("R2", "sdctrl mask", m, 8'h4B);
        wr(8'h46, 8'hFF); rd(8'h46, m, g); check("R2", "almctrl mask", m, 8'h80);

        // R6 disabled: hot temperature has no effect
        wr(8'h46, 8'h00);
        wr(8'h40, 8'h08);
        temp_mdc = TW'(200000);
        base = irq_cnt;
        repeat (3 * SLOW) @(negedge clk);
        rd(8'h08, m, g);
        check("R6", "status while off", m, 8'h00);
        check("R6", "status first while off", g, 8'h00);
        check("R6", "shutdowns while off", {s2_m, s3_m}, 2'b00);
        check("R6", "no pulse while off", irq_cnt - base, 0);

        // R3 R4 R5 R9 R10 table walk, fast rate, enabled
        wr(8'h46, 8'h80);
        for (int i = 0; i < 16; i++) begin
            wr(8'h40, {4'b0000, 1'b1, 1'b0, VEC[i][23:22]});
            temp_mdc = VEC[i][21:4];
            repeat (2 * FAST + 2) @(negedge clk);
            rd(8'h08, m, g);
            check("R4", $sformatf("vec %0d second status", i), m, code_of(VEC[i][3:2]));
            check("R5", $sformatf("vec %0d first status", i), g, {6'b0, VEC[i][1:0]});
            check("R9", $sformatf("vec %0d stage3 shutdown", i), s3_m, VEC[i][3:2] == 2'd3);
            check("R10", $sformatf("vec %0d stage2 shutdown", i), s2_m, VEC[i][3:2] >= 2'd2);
        end

        // R10 override
        wr(8'h40, 8'h48);
        temp_mdc = TW'(120000);
        repeat (2 * FAST + 2) @(negedge clk);
        check("R10", "override at stage 2", {s2_m, s3_m}, 2'b00);
        temp_mdc = TW'(150000);
        repeat (2 * FAST + 2) @(negedge clk);
        check("R9", "override leaves stage 3", {s2_m, s3_m}, 2'b01);
        wr(8'h40, 8'h08);
        @(negedge clk);
        check("R10", "override cleared", {s2_m, s3_m}, 2'b11);

        // R7 fast tick spacing
        reg_addr = 8'h08;
        temp_mdc = TW'(37000);
        wait_irq(4 * FAST, "R7");
        temp_mdc = TW'(100000);
        repeat (FAST - 1) @(negedge clk);
        #1; check("R7", "fast: stage held before tick", rdata_m, 8'h00);
        @(negedge clk);
        #1; check("R7", "fast: stage at tick", rdata_m, 8'h10);
        check("R8", "pulse at fast tick", irq_m, 1'b1);

        // R7 slow tick spacing
        wr(8'h40, 8'h00);
        reg_addr = 8'h08;
        temp_mdc = TW'(37000);
        wait_irq(4 * SLOW, "R7");
        temp_mdc = TW'(115000);
        repeat (SLOW - 1) @(negedge clk);
        #1; check("R7", "slow: stage held before tick", rdata_m, 8'h00);
        @(negedge clk);
        #1; check("R7", "slow: stage at tick", rdata_m, 8'h30);

        // R8 no pulse within same stage, one pulse on change
        base = irq_cnt;
        temp_mdc = TW'(118000);
        repeat (3 * SLOW) @(negedge clk);
        check("R8", "no pulse inside stage", irq_cnt - base, 0);
        temp_mdc = TW'(145000);
        repeat (2 * SLOW + 2) @(negedge clk);
        check("R8", "one pulse on change", irq_cnt - base, 1);
        check("R9", "stage 3 reached slow", s3_m, 1'b1);

        // R6 disable while at stage 3
        base = irq_cnt;
        wr(8'h46, 8'h00);
        repeat (3) @(negedge clk);
        rd(8'h08, m, g);
        check("R6", "status after disable", m, 8'h00);
        check("R6", "shutdowns after disable", {s2_m, s3_m}, 2'b00);
        check("R6", "no pulse on disable", irq_cnt - base, 0);

        check("R8", "pulse width one cycle", irq_wide, 0);
        finish_run();
    end

endmodule